// File: doc/BRIEF.md
# Color Subcarrier Phase Synthesizer

This block is a direct digital synthesizer for the color subcarrier of an analog television encoder. A 32-bit phase accumulator is advanced once per pixel by a frequency word. The top bits of the accumulator form the phase that addresses a downstream sine table. The block runs from the master clock and makes its own pixel-rate enable, one master cycle in two.

Software writes the frequency word one byte at a time. The word is held in a staging area and only becomes active when its most significant byte arrives, so a half-written word is never used. A 3-bit field counter follows the field strobe. It wraps after four fields in 525-line mode and after eight fields in 625-line mode. At each wrap the accumulator restarts from zero, so the phase sequence repeats exactly. In genlock mode the frequency comes from an external word, and a line strobe loads the accumulator from an external phase word.

Top module: `subcarrier_dds`

## Requirements
- R1: While `rst` is high, and after it is released, `phase_out` and `field_idx` are 0 and the active frequency word is 0. With `genlock_en` at 0 and no strobes, the phase therefore stays at 0.
- R2: A write sets byte k (bits 8k+7:8k) of the frequency word, where k is `cfg_addr`. Writes to addresses 0, 1 and 2 only stage their bytes. A write to address 3 makes the full word active: byte 3 is taken from that write and bytes 0 to 2 from the staging area.
- R3: The accumulator changes only on the second rising edge after reset release, and then on every second edge after that (the pixel edge). On each pixel edge it adds the selected frequency word, modulo 2^32. Strobes are sampled on pixel edges only, so they must be held for two master cycles.
- R4: `phase_out` equals bits 31:22 of the accumulator.
- R5: On a pixel edge with `field_start` high, `field_idx` increments. When `field_idx` is at or above its limit, it returns to 0 instead. The limit is 3 with `mode625`=0 and 7 with `mode625`=1.
- R6: On a pixel edge where the field counter wraps, the accumulator is set to 0 instead of being advanced.
- R7: With `genlock_en`=1 the accumulator advances by `gl_freq`, and the register word has no effect.
- R8: With `genlock_en`=1, a pixel edge with `line_start` high loads the accumulator with `gl_phase`. This load takes priority over the wrap clear of R6.
- R9: With `genlock_en`=0, `line_start`, `gl_freq` and `gl_phase` have no effect on the phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock (twice the pixel rate) |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Frequency byte write strobe |
| cfg_addr | input | 2 | Byte index of the frequency word |
| cfg_wdata | input | 8 | Byte to write |
| genlock_en | input | 1 | Use the genlock frequency and phase words |
| gl_freq | input | 32 | Genlock frequency word |
| gl_phase | input | 32 | Genlock phase word, loaded on a line strobe |
| line_start | input | 1 | Start-of-line strobe |
| field_start | input | 1 | Start-of-field strobe |
| mode625 | input | 1 | 1 selects the 8-field sequence, 0 the 4-field sequence |
| phase_out | output | 10 | Subcarrier phase for the sine lookup |
| field_idx | output | 3 | Position in the field sequence |

## Verification
The hardest case to reach from the ports is a field counter sitting above the 525-line limit. It can only get there by counting past 3 in 625-line mode and then switching modes. The stimulus therefore steps through the 8-field sequence to position 5, clears `mode625`, and sends one more field strobe; the counter must return to 0 and the phase must clear. The other hard case is a genlock line load and a sequence wrap on the same pixel edge. The bench builds it by walking the counter to its limit with genlock on, then raising both strobes together.

// File: rtl/scdds_pkg.sv
package scdds_pkg;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_ADD   = 2'd1,
        OP_CLEAR = 2'd2,
        OP_LOAD  = 2'd3
    } acc_op_t;

    typedef struct packed {
        logic pen;         // pixel edge
        logic field_wrap;  // field sequence boundary on this pixel
        logic line_load;   // genlock phase load requested
    } seq_evt_t;

    // Load wins over clear; nothing moves off the pixel edge.
    function automatic acc_op_t pick_op(seq_evt_t e);
        if (!e.pen)           return OP_HOLD;
        else if (e.line_load) return OP_LOAD;
        else if (e.field_wrap) return OP_CLEAR;
        else                  return OP_ADD;
    endfunction

endpackage

// File: rtl/scdds_freq_regs.sv
module scdds_freq_regs #(
    parameter int ACC_W  = 32,
    parameter int BYTE_W = 8,
    localparam int NB     = ACC_W / BYTE_W,
    localparam int ADDR_W = $clog2(NB)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [ACC_W-1:0]  active
);
    localparam int STG_W = ACC_W - BYTE_W;

    logic [STG_W-1:0] staged;

    genvar b;
    generate
        for (b = 0; b < NB - 1; b++) begin : g_stage
            logic [BYTE_W-1:0] byte_q;
            always_ff @(posedge clk) begin
                if (rst)
                    byte_q <= '0;
                else if (we && addr == ADDR_W'(b))
                    byte_q <= wdata;
            end
            assign staged[b*BYTE_W +: BYTE_W] = byte_q;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)
            active <= '0;
        else if (we && addr == ADDR_W'(NB - 1))
            active <= {wdata, staged};
    end

    // R2: lower-byte writes never disturb the active word
    assert_shadow_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (we && addr != ADDR_W'(NB - 1)) |=> $stable(active));

endmodule

// File: rtl/scdds_field_seq.sv
module scdds_field_seq #(
    parameter int FIELD_W     = 3,
    parameter int NTSC_FIELDS = 4,
    parameter int PAL_FIELDS  = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               pen,
    input  logic               field_start,
    input  logic               mode625,
    output logic [FIELD_W-1:0] cnt,
    output logic               wrap
);
    localparam logic [FIELD_W-1:0] LAST_525 = FIELD_W'(NTSC_FIELDS - 1);
    localparam logic [FIELD_W-1:0] LAST_625 = FIELD_W'(PAL_FIELDS - 1);

    logic [FIELD_W-1:0] last;
    logic               step;

    assign last = mode625 ? LAST_625 : LAST_525;
    assign step = pen && field_start;
    assign wrap = step && (cnt >= last);

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (step)
            cnt <= wrap ? '0 : cnt + 1'b1;
    end

    // R5: at or above the limit the next field returns to zero
    assert_field_wrap_R5: assert property (@(posedge clk) disable iff (rst)
        (pen && field_start && cnt >= last) |=> (cnt == '0));

    // R5: counter only moves on a pixel edge with a field strobe
    assert_field_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !(pen && field_start) |=> $stable(cnt));

endmodule

// File: rtl/scdds_phase_acc.sv
module scdds_phase_acc
    import scdds_pkg::*;
#(
    parameter int ACC_W   = 32,
    parameter int PHASE_W = 10
) (
    input  logic               clk,
    input  logic               rst,
    input  acc_op_t            op,
    input  logic [ACC_W-1:0]   freq,
    input  logic [ACC_W-1:0]   load_val,
    output logic [PHASE_W-1:0] phase
);
    logic [ACC_W-1:0] acc;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc <= '0;
        end else begin
            unique case (op)
                OP_ADD:   acc <= acc + freq;
                OP_CLEAR: acc <= '0;
                OP_LOAD:  acc <= load_val;
                default:  acc <= acc;
            endcase
        end
    end

    assign phase = acc[ACC_W-1 -: PHASE_W];

endmodule

// File: rtl/subcarrier_dds.sv
module subcarrier_dds
    import scdds_pkg::*;
#(
    parameter int ACC_W       = 32,
    parameter int PHASE_W     = 10,
    parameter int BYTE_W      = 8,
    parameter int FIELD_W     = 3,
    parameter int NTSC_FIELDS = 4,
    parameter int PAL_FIELDS  = 8,
    localparam int ADDR_W     = $clog2(ACC_W / BYTE_W)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_we,
    input  logic [ADDR_W-1:0]  cfg_addr,
    input  logic [BYTE_W-1:0]  cfg_wdata,
    input  logic               genlock_en,
    input  logic [ACC_W-1:0]   gl_freq,
    input  logic [ACC_W-1:0]   gl_phase,
    input  logic               line_start,
    input  logic               field_start,
    input  logic               mode625,
    output logic [PHASE_W-1:0] phase_out,
    output logic [FIELD_W-1:0] field_idx
);
    logic             pen;
    logic             wrap;
    logic [ACC_W-1:0] reg_freq;
    logic [ACC_W-1:0] freq_sel;
    seq_evt_t         evt;
    acc_op_t          op;

    // pixel-rate enable: master clock divided by two
    always_ff @(posedge clk) begin
        if (rst) pen <= 1'b0;
        else     pen <= ~pen;
    end

    scdds_freq_regs #(.ACC_W(ACC_W), .BYTE_W(BYTE_W)) i_freq (
        .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr),
        .wdata(cfg_wdata), .active(reg_freq)
    );

    scdds_field_seq #(.FIELD_W(FIELD_W), .NTSC_FIELDS(NTSC_FIELDS),
                      .PAL_FIELDS(PAL_FIELDS)) i_seq (
        .clk(clk), .rst(rst), .pen(pen), .field_start(field_start),
        .mode625(mode625), .cnt(field_idx), .wrap(wrap)
    );

    assign freq_sel       = genlock_en ? gl_freq : reg_freq;
    assign evt.pen        = pen;
    assign evt.field_wrap = wrap;
    assign evt.line_load  = genlock_en && line_start;
    assign op             = pick_op(evt);

    scdds_phase_acc #(.ACC_W(ACC_W), .PHASE_W(PHASE_W)) i_acc (
        .clk(clk), .rst(rst), .op(op), .freq(freq_sel),
        .load_val(gl_phase), .phase(phase_out)
    );

    // R3: phase frozen on non-pixel edges
    assert_pixel_rate_R3: assert property (@(posedge clk) disable iff (rst)
        !pen |=> $stable(phase_out));

    // R6: sequence wrap without a genlock load clears the phase
    assert_wrap_clear_R6: assert property (@(posedge clk) disable iff (rst)
        (wrap && !(genlock_en && line_start)) |=> (phase_out == '0));

    // R8: genlock line strobe loads the external phase
    assert_gl_load_R8: assert property (@(posedge clk) disable iff (rst)
        (pen && genlock_en && line_start)
        |=> (phase_out == $past(gl_phase[ACC_W-1 -: PHASE_W])));

endmodule

// File: tb/test_subcarrier_dds.sv
module test_subcarrier_dds;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic        genlock_en = 1'b0;
    logic [31:0] gl_freq = '0;
    logic [31:0] gl_phase = '0;
    logic        line_start = 1'b0;
    logic        field_start = 1'b0;
    logic        mode625 = 1'b0;
    logic [9:0]  phase_out;
    logic [2:0]  field_idx;

    subcarrier_dds i_subcarrier_dds (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .genlock_en(genlock_en), .gl_freq(gl_freq),
        .gl_phase(gl_phase), .line_start(line_start),
        .field_start(field_start), .mode625(mode625),
        .phase_out(phase_out), .field_idx(field_idx)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        logic [9:0] ph;
        logic [2:0] fld;
        string      tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done = 0;

    // reference model state, built from the requirements
    logic [31:0] m_acc, m_act, m_stage;
    logic [2:0]  m_cnt;

    task automatic model_reset();
        m_acc = '0; m_act = '0; m_stage = '0; m_cnt = '0;
    endtask

    // one pixel: two master cycles, strobes held throughout
    task automatic pix(input bit fs, input bit ls, input string tag);
        logic [2:0] last;
        bit wrap;
        field_start = fs;
        line_start  = ls;
        @(negedge clk);
        @(negedge clk);
        last = mode625 ? 3'd7 : 3'd3;
        wrap = fs && (m_cnt >= last);
        if (genlock_en && ls)  m_acc = gl_phase;
        else if (wrap)         m_acc = '0;
        else                   m_acc = m_acc + (genlock_en ? gl_freq : m_act);
        if (fs) m_cnt = wrap ? 3'd0 : m_cnt + 3'd1;
        q.push_back('{m_acc[31:22], m_cnt, tag});
        field_start = 1'b0;
        line_start  = 1'b0;
    endtask

    // register write spanning one pixel (idempotent on both edges)
    task automatic wr(input logic [1:0] a, input logic [7:0] d, input string tag);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        if (a == 2'd3) m_act = {d, m_stage[23:0]};
        else           m_stage[a*8 +: 8] = d;
        pix(1'b0, 1'b0, tag);
        cfg_we = 1'b0;
    endtask

    task automatic wr_word(input logic [31:0] w, input string tag);
        for (int k = 0; k < 4; k++) wr(2'(k), w[k*8 +: 8], tag);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        model_reset();
        repeat (3) @(negedge clk);
        checks++;
        if (phase_out !== 10'd0 || field_idx !== 3'd0) begin
            errors++;
            $display("FAIL R1 in reset: phase=%0d field=%0d expected 0 0",
                     phase_out, field_idx);
        end
        rst = 1'b0;
    endtask

    // monitor: pop and compare
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (phase_out !== e.ph || field_idx !== e.fld) begin
                    errors++;
                    $display("FAIL %s: phase=%0d field=%0d expected phase=%0d field=%0d",
                             e.tag, phase_out, field_idx, e.ph, e.fld);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1: zero frequency after reset keeps phase at 0
        repeat (3) pix(1'b0, 1'b0, "R1");

        // R2 R3: word assembled from bytes; one step per pixel
        wr_word(32'h1000_0000, "R2");
        repeat (5) pix(1'b0, 1'b0, "R3");

        // R4: carries from low bits into the phase field
        wr_word(32'h0123_4567, "R4");
        repeat (6) pix(1'b0, 1'b0, "R4");

        // R2: staged lower bytes do not change the active word
        wr(2'd0, 8'hFF, "R2_stage");
        wr(2'd1, 8'hFF, "R2_stage");
        wr(2'd2, 8'hFF, "R2_stage");
        repeat (3) pix(1'b0, 1'b0, "R2_stage");
        wr(2'd3, 8'h20, "R2_commit");
        repeat (3) pix(1'b0, 1'b0, "R2_commit");

        // R3: modulo 2^32 wrap of the accumulator
        wr_word(32'hF000_0001, "R3_wrap");
        repeat (20) pix(1'b0, 1'b0, "R3_wrap");

        // R5 R6: four-field sequence with clear on wrap
        wr_word(32'h0300_0000, "R5");
        for (int f = 0; f < 4; f++) begin
            pix(1'b1, 1'b0, "R5_R6_ntsc");
            repeat (2) pix(1'b0, 1'b0, "R5");
        end

        // R5 R6: eight-field sequence
        mode625 = 1'b1;
        for (int f = 0; f < 8; f++) begin
            pix(1'b1, 1'b0, "R5_R6_pal");
            pix(1'b0, 1'b0, "R5");
        end

        // R5: counter above 525-line limit after mode change
        for (int f = 0; f < 5; f++) pix(1'b1, 1'b0, "R5");
        pix(1'b0, 1'b0, "R5");
        mode625 = 1'b0;
        pix(1'b1, 1'b0, "R5_over_limit");
        repeat (2) pix(1'b0, 1'b0, "R6");

        // R9: genlock words and line strobe ignored when genlock off
        gl_freq  = 32'h7000_0000;
        gl_phase = 32'hABCD_0000;
        repeat (2) pix(1'b0, 1'b1, "R9");
        pix(1'b0, 1'b0, "R9");

        // R7: frequency from genlock word
        genlock_en = 1'b1;
        gl_freq    = 32'h0800_0000;
        repeat (4) pix(1'b0, 1'b0, "R7");
        wr_word(32'h4000_0000, "R7_reg_ignored");
        repeat (2) pix(1'b0, 1'b0, "R7");

        // R8: line strobe loads genlock phase
        gl_phase = 32'h4000_0000;
        pix(1'b0, 1'b1, "R8_load");
        repeat (3) pix(1'b0, 1'b0, "R8");

        // R8: load beats the wrap clear on the same pixel
        for (int f = 0; f < 3; f++) pix(1'b1, 1'b0, "R5");
        gl_phase = 32'h9C40_0000;
        pix(1'b1, 1'b1, "R8_priority");
        pix(1'b0, 1'b0, "R8");

        // R1: second reset after activity
        genlock_en = 1'b0;
        do_reset();
        repeat (3) pix(1'b0, 1'b0, "R1_again");

        @(negedge clk);
        #2;
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule